// File: doc/BRIEF.md
# Programmable Tone Divider with Melody Output

This block turns a system clock into the timing for a telephony tone source. Three byte registers sit on a small write/read register bus: a high-group frequency byte, a low-group frequency byte and a control byte. A tone clock is derived from the system clock, either as the clock itself or as one third of it. The high-group byte sets the period of a square wave: every period is split into 23 equal sub-steps of (x+2) tone-clock ticks each, and the wave is high for the first 12 of them. The low-group byte is only stored and read back, for the sine path outside this block.

Two shared port pins can carry the block's outputs. Each pin has its own enable bit in the control byte. When the enable is clear, the pin shows the value of its port latch. When the enable is set, the pin shows the alternate signal ANDed with that latch, so the latch must be held at 1. One pin carries the melody square wave and the other carries the tone clock. Port access is not blocked while an alternate function is enabled.

The melody generator is a three-state machine. In MEL_IDLE the wave is high and no period runs. MEL_HIGH covers sub-steps 0 to 11 and MEL_LOW covers sub-steps 12 to 22. The transitions are: IDLE_TO_HIGH on a tone tick when the high-group byte is non-zero, which also latches that byte; HIGH_TO_LOW when sub-step 11 ends; LOW_TO_HIGH at the end of sub-step 22 when the byte is non-zero, which latches the new value; LOW_TO_IDLE at the same boundary when the byte is zero.

Top module: `tone_gen_core`

## Requirements
- R1: After a synchronous reset, all three registers read 0x00 and both shared pins equal their port latch inputs.
- R2: The high-group byte is at address 0x11, the low-group byte at 0x12 and the control byte at 0x13. Each reads back what was written, except that control bits 7..3 always read as 0.
- R3: A write to any address other than 0x11, 0x12 or 0x13 changes no register.
- R4: With control bit 1 = 0 and a non-zero high-group value x, the melody wave is high for exactly 12·(x+2) clocks and low for exactly 11·(x+2) clocks. This holds for x = 1 and x = 2 up to x = 255.
- R5: With control bit 1 = 1, the tone clock runs at one third of the system clock, so every high and low time of R4 becomes three times as long.
- R6: With a high-group value of zero, the melody wave stays high once the running period has finished.
- R7: A new high-group value takes effect only at the next period boundary. The period in progress completes with the old value.
- R8: Control bit 0 selects the melody pin. When it is 0 the pin equals its port latch. When it is 1 the pin equals the melody wave AND the latch.
- R9: Control bit 2 selects the clock pin. When it is 0 the pin equals its latch. When it is 1 the pin equals the tone clock AND the latch. The tone clock is the system clock itself when bit 1 = 0, and a 50 % square wave at one third of it when bit 1 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 8 | Read address |
| bus_rdata | output | 8 | Read data (combinational) |
| mel_port_q | input | 1 | Port latch of the melody pin |
| clk_port_q | input | 1 | Port latch of the clock pin |
| mel_pin | output | 1 | Melody pin value |
| clk_pin | output | 1 | Tone-clock pin value |

## Verification
The bench sweeps the high-group value over every value from 1 to 40, plus several large values, and times each high and low run exactly against 12·(x+2) and 11·(x+2). An off-by-one in the sub-step limit or the tick count would make a run one step or one tick too long or short. The divide-by-three mode is timed the same way, together with the half-cycle samples of the clock pin. A divider with the wrong duty cycle, or one that does not reset, would show uneven high runs. The bench also rewrites the value in the middle of a period, where a design that applies it at once would cut short the low run in progress. It writes zero to check for a steady high, and probes unused and aliased addresses. It clears the port latches to catch a pin that ignores the AND with its latch.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        MEL_IDLE = 2'd0,
        MEL_HIGH = 2'd1,
        MEL_LOW  = 2'd2
    } mel_state_e;

    // control byte, bit 2 down to bit 0
    typedef struct packed {
        logic clk_out_en;
        logic div3_en;
        logic mel_en;
    } tone_ctrl_t;

endpackage

// File: rtl/tone_regs.sv
module tone_regs
    import tone_pkg::*;
#(
    parameter int             AW   = 8,
    parameter int             DW   = 8,
    parameter logic [AW-1:0]  BASE = 8'h11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] hi_grp,
    output logic [DW-1:0] lo_grp,
    output tone_ctrl_t    ctrl
);
    localparam logic [AW-1:0] A_HI = BASE;
    localparam logic [AW-1:0] A_LO = AW'(BASE + 1);
    localparam logic [AW-1:0] A_CT = AW'(BASE + 2);

    logic [DW-1:0] hi_q, lo_q;
    tone_ctrl_t    ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            ctl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_HI) hi_q  <= wr_data;
            if (wr_addr == A_LO) lo_q  <= wr_data;
            if (wr_addr == A_CT) ctl_q <= tone_ctrl_t'(wr_data[2:0]);
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_HI) rd_data = hi_q;
        else if (rd_addr == A_LO) rd_data = lo_q;
        else if (rd_addr == A_CT) rd_data[2:0] = ctl_q;
    end

    assign hi_grp = hi_q;
    assign lo_grp = lo_q;
    assign ctrl   = ctl_q;

    // R3
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != A_HI && wr_addr != A_LO && wr_addr != A_CT)
        |=> ($stable(hi_q) && $stable(lo_q) && $stable(ctl_q)));

endmodule

// File: rtl/tone_clkdiv.sv
module tone_clkdiv #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_en,
    output logic tick,
    output logic sq_out
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = (DIV - 1) / 2;

    logic [CW-1:0] cnt;
    logic          hi_pos, hi_neg;

    always_ff @(posedge clk) begin
        if (!rst_n || !div_en) cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign hi_pos = div_en && (cnt < CW'(HALF));

    // half-cycle extension gives an even duty on an odd ratio
    always_ff @(negedge clk) begin
        if (!rst_n) hi_neg <= 1'b0;
        else hi_neg <= hi_pos;
    end

    assign tick   = div_en ? (cnt == CW'(DIV - 1)) : 1'b1;
    assign sq_out = div_en ? (hi_pos | hi_neg) : clk;

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_en) |=> (!tick || !div_en));

endmodule

// File: rtl/tone_melody.sv
module tone_melody
    import tone_pkg::*;
#(
    parameter int DW         = 8,
    parameter int STEPS      = 23,
    parameter int HIGH_STEPS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] hi_grp,
    output logic          wave
);
    localparam int SW = $clog2(STEPS);

    mel_state_e    state, state_nx;
    logic [DW-1:0] lat;
    logic [DW:0]   cyc;
    logic [SW-1:0] step;
    logic          step_done, start, period_end;

    assign step_done  = tick && (state != MEL_IDLE) && (cyc == ({1'b0, lat} + 1'b1));
    assign period_end = step_done && (step == SW'(STEPS - 1));
    assign start      = tick && (state == MEL_IDLE) && (hi_grp != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MEL_IDLE;
        else state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            MEL_IDLE: if (start) state_nx = MEL_HIGH;
            MEL_HIGH: if (step_done && step == SW'(HIGH_STEPS - 1)) state_nx = MEL_LOW;
            MEL_LOW:  if (period_end) state_nx = (hi_grp == '0) ? MEL_IDLE : MEL_HIGH;
            default:  state_nx = MEL_IDLE;
        endcase
    end

    // period counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat  <= '0;
            cyc  <= '0;
            step <= '0;
        end else if (start || period_end) begin
            lat  <= hi_grp;
            cyc  <= '0;
            step <= '0;
        end else if (tick && state != MEL_IDLE) begin
            if (step_done) begin
                cyc  <= '0;
                step <= step + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            MEL_LOW: wave = 1'b0;
            default: wave = 1'b1;
        endcase
    end

    // R4
    fall_at_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wave) |-> ($past(step) == SW'(HIGH_STEPS - 1)));

    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step < SW'(STEPS));

    // R7
    latch_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat) |-> ($past(step) == SW'(STEPS - 1) || $past(state) == MEL_IDLE));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MEL_IDLE && !(tick && hi_grp != '0)) |=> state == MEL_IDLE);

endmodule

// File: rtl/tone_gen_core.sv
module tone_gen_core
    import tone_pkg::*;
#(
    parameter int            ADDR_W     = 8,
    parameter int            DATA_W     = 8,
    parameter logic [7:0]    REG_BASE   = 8'h11,
    parameter int            TONE_DIV   = 3,
    parameter int            STEPS      = 23,
    parameter int            HIGH_STEPS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mel_port_q,
    input  logic              clk_port_q,
    output logic              mel_pin,
    output logic              clk_pin
);
    logic [DATA_W-1:0] hi_grp, lo_grp;
    tone_ctrl_t        ctrl;
    logic              tick, tone_sq, mel_wave;

    tone_regs #(
        .AW  (ADDR_W),
        .DW  (DATA_W),
        .BASE(ADDR_W'(REG_BASE))
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .wr_addr(bus_waddr),
        .wr_data(bus_wdata),
        .rd_addr(bus_raddr),
        .rd_data(bus_rdata),
        .hi_grp (hi_grp),
        .lo_grp (lo_grp),
        .ctrl   (ctrl)
    );

    tone_clkdiv #(.DIV(TONE_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div_en(ctrl.div3_en),
        .tick  (tick),
        .sq_out(tone_sq)
    );

    tone_melody #(
        .DW        (DATA_W),
        .STEPS     (STEPS),
        .HIGH_STEPS(HIGH_STEPS)
    ) u_mel (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hi_grp(hi_grp),
        .wave  (mel_wave)
    );

    // pin multiplexing: alternate signal gated by the port latch
    always_comb begin
        mel_pin = ctrl.mel_en     ? (mel_wave & mel_port_q) : mel_port_q;
        clk_pin = ctrl.clk_out_en ? (tone_sq  & clk_port_q) : clk_port_q;
    end

    // R8
    mel_latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mel_port_q |-> !mel_pin);

endmodule

// File: tb/tone_gen_core_tb.sv
module tone_gen_core_tb;
    logic       clk;
    logic       rst_n;
    logic       bus_wr;
    logic [7:0] bus_waddr, bus_wdata, bus_raddr;
    logic [7:0] bus_rdata;
    logic       mel_port_q, clk_port_q;
    logic       mel_pin, clk_pin;

    int total = 0;
    int bad   = 0;

    tone_gen_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata),
        .mel_port_q(mel_port_q),
        .clk_port_q(clk_port_q),
        .mel_pin   (mel_pin),
        .clk_pin   (clk_pin)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_raddr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    // times one full high run and the low run that follows
    task automatic measure(input int exp_hi, input int exp_lo, input string req);
        int hi = 0;
        int lo = 0;
        int g  = 0;
        while (mel_pin !== 1'b0 && g < 40000) begin @(negedge clk); g++; end
        while (mel_pin !== 1'b1 && g < 40000) begin @(negedge clk); g++; end
        while (mel_pin === 1'b1 && g < 40000) begin hi++; @(negedge clk); g++; end
        while (mel_pin === 1'b0 && g < 40000) begin lo++; @(negedge clk); g++; end
        check(hi == exp_hi, req, hi, exp_hi);
        check(lo == exp_lo, req, lo, exp_lo);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_waddr = '0; bus_wdata = '0; bus_raddr = '0;
        mel_port_q = 1'b1; clk_port_q = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk(8'h11, 8'h00, "R1 hi reset");
        rd_chk(8'h12, 8'h00, "R1 lo reset");
        rd_chk(8'h13, 8'h00, "R1 ctrl reset");
        check(mel_pin === 1'b1, "R1 mel pin", mel_pin, 1);
        check(clk_pin === 1'b0, "R1 clk pin", clk_pin, 0);

        // R2: readback, upper control bits read zero
        wr(8'h11, 8'hA5); wr(8'h12, 8'h3C); wr(8'h13, 8'hF8);
        rd_chk(8'h11, 8'hA5, "R2 hi");
        rd_chk(8'h12, 8'h3C, "R2 lo");
        rd_chk(8'h13, 8'h00, "R2 ctrl upper");
        wr(8'h13, 8'hFF);
        rd_chk(8'h13, 8'h07, "R2 ctrl");

        // R3: stray addresses
        wr(8'h10, 8'h00); wr(8'h14, 8'h00); wr(8'h91, 8'h00); wr(8'h00, 8'h00); wr(8'hFF, 8'h00);
        rd_chk(8'h11, 8'hA5, "R3 hi kept");
        rd_chk(8'h12, 8'h3C, "R3 lo kept");
        rd_chk(8'h13, 8'h07, "R3 ctrl kept");

        // R8: enable clear -> pin follows latch
        wr(8'h13, 8'h00);
        mel_port_q = 1'b0; #1;
        check(mel_pin === 1'b0, "R8 latch 0", mel_pin, 0);
        mel_port_q = 1'b1; #1;
        check(mel_pin === 1'b1, "R8 latch 1", mel_pin, 1);

        // R4: sweep with divide off
        wr(8'h13, 8'h01);
        for (int x = 1; x <= 40; x++) begin
            wr(8'h11, 8'(x));
            measure(12 * (x + 2), 11 * (x + 2), $sformatf("R4 x=%0d", x));
        end
        wr(8'h11, 8'd60);  measure(12 * 62,  11 * 62,  "R4 x=60");
        wr(8'h11, 8'd128); measure(12 * 130, 11 * 130, "R4 x=128");
        wr(8'h11, 8'd255); measure(12 * 257, 11 * 257, "R4 x=255");

        // R5: divide by three
        wr(8'h13, 8'h03);
        wr(8'h11, 8'd2);  measure(36 * 4,  33 * 4,  "R5 x=2");
        wr(8'h11, 8'd3);  measure(36 * 5,  33 * 5,  "R5 x=3");
        wr(8'h11, 8'd7);  measure(36 * 9,  33 * 9,  "R5 x=7");
        wr(8'h11, 8'd20); measure(36 * 22, 33 * 22, "R5 x=20");
        wr(8'h13, 8'h01);

        // R7: change mid-period applies at next boundary
        begin
            int hi = 0;
            int lo = 0;
            int g  = 0;
            wr(8'h11, 8'd5);
            measure(12 * 7, 11 * 7, "R7 setup");
            while (mel_pin !== 1'b1 && g < 40000) begin @(negedge clk); g++; end
            repeat (3) @(negedge clk);
            wr(8'h11, 8'd10);
            while (mel_pin === 1'b1 && g < 40000) begin @(negedge clk); g++; end
            while (mel_pin === 1'b0 && g < 40000) begin lo++; @(negedge clk); g++; end
            while (mel_pin === 1'b1 && g < 40000) begin hi++; @(negedge clk); g++; end
            check(lo == 11 * 7,  "R7 old low", lo, 11 * 7);
            check(hi == 12 * 12, "R7 new high", hi, 12 * 12);
        end

        // R6: zero value -> steady high
        begin
            int lows = 0;
            wr(8'h11, 8'd0);
            repeat (23 * 12 + 10) @(negedge clk);
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (mel_pin !== 1'b1) lows++;
            end
            check(lows == 0, "R6 steady high", lows, 0);
        end

        // R8: enable set, latch 0 masks wave
        begin
            int highs = 0;
            wr(8'h11, 8'd3);
            mel_port_q = 1'b0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (mel_pin !== 1'b0) highs++;
            end
            check(highs == 0, "R8 masked", highs, 0);
            mel_port_q = 1'b1;
        end

        // R9: clock pin, divide off
        clk_port_q = 1'b1;
        wr(8'h13, 8'h04);
        begin
            int errs = 0;
            for (int i = 0; i < 10; i++) begin
                @(posedge clk); #5;
                if (clk_pin !== 1'b1) errs++;
                @(negedge clk); #5;
                if (clk_pin !== 1'b0) errs++;
            end
            check(errs == 0, "R9 full rate", errs, 0);
        end

        // R9: clock pin, divide by three
        wr(8'h13, 8'h06);
        repeat (4) @(negedge clk);
        begin
            int highs = 0;
            int run   = 0;
            int maxr  = 0;
            int lrun  = 0;
            int maxl  = 0;
            for (int i = 0; i < 60; i++) begin
                if (i % 2 == 0) begin @(posedge clk); #5; end
                else begin @(negedge clk); #5; end
                if (clk_pin === 1'b1) begin
                    highs++; run++; lrun = 0;
                    if (run > maxr) maxr = run;
                end else begin
                    run = 0; lrun++;
                    if (lrun > maxl) maxl = lrun;
                end
            end
            check(highs == 30, "R9 third duty", highs, 30);
            check(maxr == 3, "R9 third high run", maxr, 3);
            check(maxl == 3, "R9 third low run", maxl, 3);
        end

        // R9: latch 0 masks, enable 0 follows latch
        begin
            int highs = 0;
            clk_port_q = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk); #5;
                if (clk_pin !== 1'b0) highs++;
            end
            check(highs == 0, "R9 masked", highs, 0);
        end
        clk_port_q = 1'b1;
        wr(8'h13, 8'h00);
        @(posedge clk); #5;
        check(clk_pin === 1'b1, "R9 disabled high", clk_pin, 1);
        @(negedge clk); #5;
        check(clk_pin === 1'b1, "R9 disabled low phase", clk_pin, 1);

        summary();
    end

endmodule